// File: doc/BRIEF.md
# Snoop outcome resolver

This block sits at the head of the in-order queue of a pipelined, split-transaction system bus. In the snoop window of the oldest transaction it samples three wired-OR lines: a clean hit from caching agents, a dirty (modified) hit, and a defer line that only the chipset or a priority agent drives. It combines them with the request attributes into the final outcome of that transaction. The result is a 3-bit response code, a data-transfer size, an indication that a snooping agent supplies the data, and an enable that lets memory capture the written-back line as it passes.

A clean hit and a dirty hit driven together mean that some agent could not answer in time. The resolver then waits and samples the lines again two clocks later, and it bounds how many times in a row this may happen. A dirty hit always wins over defer. A parity error in the request phase raises an address-error pulse and drops any outcome that is pending.

Top module: `snoop_resolver`

## Requirements
- R1: After reset every output is 0 and stays 0 until the first sample.
- R2: A sample with no dirty hit, no defer and no stall gives a normal-data response, code 3'b000, for request kind 2'b00 (full line, size code 2'b10) and for kind 2'b01 (partial of 8 bytes or less, size code 2'b01). Kind 2'b10 (invalidate) gives no-data code 3'b001 with size code 2'b00. Reserved kind 2'b11 gives hard failure, code 3'b111, size 2'b00.
- R3: A clean hit without a dirty hit leaves the response and size as in R2 and sets the shared output. Shared is 0 in every other case.
- R4: A dirty hit without a clean hit gives implicit-writeback code 3'b010 with line size 2'b10, and both the writeback-source and memory-capture outputs are set, whatever the defer line shows.
- R5: Defer without a dirty hit gives deferred code 3'b011 when the retry select is 0, or retry code 3'b100 when it is 1. In both cases the size is 2'b00 and neither writeback nor capture is set.
- R6: A clean hit and a dirty hit sampled together (with or without defer) form a stall. No response is given. The lines are sampled again exactly two clocks later, without a strobe. A strobe in the clock between is ignored.
- R7: Up to three consecutive stalls are tolerated. A fourth consecutive stall gives hard failure, code 3'b111, size 2'b00. The stall count restarts after every response.
- R8: A parity-error input raises the address-error output for exactly the next clock. It discards a strobe in the same clock and any stall still pending, and no response follows from either.
- R9: A response appears for exactly one clock, on the clock after its sample. When the valid output is 0, code, size, writeback, capture and shared are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snoop_vld | input | 1 | Snoop-window strobe for the head transaction |
| hit | input | 1 | Wired-OR clean hit (Shared or Exclusive) |
| hitm | input | 1 | Wired-OR dirty hit (Modified) |
| defer | input | 1 | Defer request from chipset or priority agent |
| retry_sel | input | 1 | With defer: 1 selects retry, 0 selects deferred |
| req_kind | input | 2 | Request kind: 00 line, 01 partial, 10 invalidate, 11 reserved |
| par_err | input | 1 | Request-phase parity error |
| resp_vld | output | 1 | Response valid, one clock |
| resp_code | output | 3 | Response code |
| data_size | output | 2 | 00 none, 01 partial, 10 full line |
| wb_src | output | 1 | A snooping agent supplies the data |
| snarf_en | output | 1 | Memory captures the written-back line |
| shared | output | 1 | Line stays held by another agent |
| addr_err | output | 1 | Address-error pulse |

## Verification
The checker assumes that the wired-OR lines and the request kind are stable in any clock where the block samples them. It also assumes that the snoop strobe is either held low or only repeated as noise while a stall recheck is pending. The bench drives every input at the falling edge and sweeps all 64 combinations of request kind, hit, dirty hit, defer and retry select. Stall chains of one to four steps run with a deliberate stray strobe in each waiting clock. Parity errors are injected both during a pending stall and together with a strobe. Each sample is followed by an idle clock, so a response never overlaps the next stimulus.

// File: rtl/snoop_resolver_pkg.sv
package snoop_resolver_pkg;

    typedef enum logic [2:0] {
        RSP_NORMAL = 3'b000,
        RSP_NODATA = 3'b001,
        RSP_IWB    = 3'b010,
        RSP_DEFER  = 3'b011,
        RSP_RETRY  = 3'b100,
        RSP_HARD   = 3'b111
    } resp_e;

    typedef enum logic [1:0] {
        KIND_LINE  = 2'b00,
        KIND_PART  = 2'b01,
        KIND_INVAL = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_PART = 2'b01,
        SZ_LINE = 2'b10
    } size_e;

    typedef enum logic [2:0] {
        OC_CLEAN,
        OC_STALL,
        OC_IWB,
        OC_DEFER,
        OC_RETRY
    } outcome_e;

    typedef struct packed {
        logic       vld;
        logic [2:0] code;
        logic [1:0] size;
        logic       wb;
        logic       snarf;
        logic       shared;
        logic       aerr;
    } out_t;

endpackage

// File: rtl/snp_classify.sv
module snp_classify
    import snoop_resolver_pkg::*;
(
    input  logic     hit,
    input  logic     hitm,
    input  logic     defer,
    input  logic     retry_sel,
    output outcome_e outcome
);
    // Stall outranks everything; dirty hit outranks defer.
    always_comb begin
        if (hit && hitm)       outcome = OC_STALL;
        else if (hitm)         outcome = OC_IWB;
        else if (defer)        outcome = retry_sel ? OC_RETRY : OC_DEFER;
        else                   outcome = OC_CLEAN;
    end
endmodule

// File: rtl/snp_stall_track.sv
module snp_stall_track #(
    parameter int MAX_STALLS = 3,
    parameter int GAP        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic sample_en,
    input  logic is_stall,
    output logic busy,
    output logic recheck,
    output logic overflow
);
    localparam int CNT_W = $clog2(MAX_STALLS + 1);
    localparam int GAP_W = (GAP > 2) ? $clog2(GAP) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        overflow = is_stall && (st_q.cnt == CNT_W'(MAX_STALLS));
        if (flush) begin
            st_d = '0;
        end else if (sample_en) begin
            if (is_stall && !overflow) begin
                st_d.busy = 1'b1;
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.gap  = GAP_W'(GAP - 1);
            end else begin
                st_d = '0;
            end
        end else if (st_q.busy && st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign recheck = st_q.busy && (st_q.gap == '0);
endmodule

// File: rtl/snp_encode.sv
module snp_encode
    import snoop_resolver_pkg::*;
(
    input  outcome_e   outcome,
    input  logic [1:0] kind,
    input  logic       overflow,
    output logic       emit,
    output logic [2:0] code,
    output logic [1:0] size,
    output logic       wb
);
    always_comb begin
        emit = 1'b1;
        code = RSP_HARD;
        size = SZ_NONE;
        wb   = 1'b0;
        case (outcome)
            OC_STALL: emit = overflow;
            OC_IWB: begin
                code = RSP_IWB;
                size = SZ_LINE;
                wb   = 1'b1;
            end
            OC_DEFER: code = RSP_DEFER;
            OC_RETRY: code = RSP_RETRY;
            default: begin
                case (kind)
                    KIND_LINE:  begin code = RSP_NORMAL; size = SZ_LINE; end
                    KIND_PART:  begin code = RSP_NORMAL; size = SZ_PART; end
                    KIND_INVAL: code = RSP_NODATA;
                    default:    code = RSP_HARD;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/snoop_resolver.sv
module snoop_resolver
    import snoop_resolver_pkg::*;
#(
    parameter int MAX_STALLS = 3,
    parameter int GAP        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snoop_vld,
    input  logic       hit,
    input  logic       hitm,
    input  logic       defer,
    input  logic       retry_sel,
    input  logic [1:0] req_kind,
    input  logic       par_err,
    output logic       resp_vld,
    output logic [2:0] resp_code,
    output logic [1:0] data_size,
    output logic       wb_src,
    output logic       snarf_en,
    output logic       shared,
    output logic       addr_err
);
    outcome_e   outcome;
    logic       busy, recheck, overflow, sample_en;
    logic       emit, enc_wb;
    logic [2:0] enc_code;
    logic [1:0] enc_size;
    out_t       out_d, out_q;

    assign sample_en = !par_err && ((snoop_vld && !busy) || recheck);

    snp_classify u_classify (
        .hit       (hit),
        .hitm      (hitm),
        .defer     (defer),
        .retry_sel (retry_sel),
        .outcome   (outcome)
    );

    snp_stall_track #(
        .MAX_STALLS (MAX_STALLS),
        .GAP        (GAP)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (par_err),
        .sample_en (sample_en),
        .is_stall  (outcome == OC_STALL),
        .busy      (busy),
        .recheck   (recheck),
        .overflow  (overflow)
    );

    snp_encode u_encode (
        .outcome  (outcome),
        .kind     (req_kind),
        .overflow (overflow),
        .emit     (emit),
        .code     (enc_code),
        .size     (enc_size),
        .wb       (enc_wb)
    );

    always_comb begin
        out_d      = '0;
        out_d.aerr = par_err;
        if (sample_en && emit) begin
            out_d.vld    = 1'b1;
            out_d.code   = enc_code;
            out_d.size   = enc_size;
            out_d.wb     = enc_wb;
            out_d.snarf  = enc_wb;
            out_d.shared = hit && !hitm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign resp_vld  = out_q.vld;
    assign resp_code = out_q.code;
    assign data_size = out_q.size;
    assign wb_src    = out_q.wb;
    assign snarf_en  = out_q.snarf;
    assign shared    = out_q.shared;
    assign addr_err  = out_q.aerr;
endmodule

// File: rtl/snoop_resolver_chk.sv
module snoop_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       par_err,
    input logic       hit,
    input logic       hitm,
    input logic       sample_en,
    input logic       recheck,
    input logic       resp_vld,
    input logic [2:0] resp_code,
    input logic [1:0] data_size,
    input logic       wb_src,
    input logic       snarf_en,
    input logic       shared,
    input logic       addr_err
);
    AST_IWB_IS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld && resp_code == 3'b010 |-> data_size == 2'b10 && wb_src && snarf_en); // R4
    AST_SNARF_MATCHES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        snarf_en == wb_src); // R4
    AST_DEFER_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld && (resp_code == 3'b011 || resp_code == 3'b100) |-> data_size == 2'b00 && !wb_src); // R5
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && hit && hitm && !recheck |=> !resp_vld); // R6
    AST_AERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> addr_err && !resp_vld); // R8
    AST_AERR_ONLY_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !par_err |=> !addr_err); // R8
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_vld |-> resp_code == 3'b000 && data_size == 2'b00 && !wb_src && !shared); // R9
    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> resp_code != 3'b101 && resp_code != 3'b110); // R2
endmodule

bind snoop_resolver snoop_resolver_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_err   (par_err),
    .hit       (hit),
    .hitm      (hitm),
    .sample_en (sample_en),
    .recheck   (recheck),
    .resp_vld  (resp_vld),
    .resp_code (resp_code),
    .data_size (data_size),
    .wb_src    (wb_src),
    .snarf_en  (snarf_en),
    .shared    (shared),
    .addr_err  (addr_err)
);

// File: tb/snoop_resolver_tb_top.sv
`timescale 1ns/100ps
module snoop_resolver_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snoop_vld = 1'b0, hit = 1'b0, hitm = 1'b0, defer = 1'b0, retry_sel = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       par_err = 1'b0;
    logic       resp_vld, wb_src, snarf_en, shared, addr_err;
    logic [2:0] resp_code;
    logic [1:0] data_size;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snoop_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .snoop_vld(snoop_vld), .hit(hit), .hitm(hitm),
        .defer(defer), .retry_sel(retry_sel), .req_kind(req_kind), .par_err(par_err),
        .resp_vld(resp_vld), .resp_code(resp_code), .data_size(data_size),
        .wb_src(wb_src), .snarf_en(snarf_en), .shared(shared), .addr_err(addr_err)
    );

    // {vld, code[2:0], size[1:0], wb, snarf, shared, aerr}
    function automatic logic [9:0] clean_exp(input logic [1:0] k, input logic h);
        case (k)
            2'b00:   return {1'b1, 3'b000, 2'b10, 1'b0, 1'b0, h, 1'b0};
            2'b01:   return {1'b1, 3'b000, 2'b01, 1'b0, 1'b0, h, 1'b0};
            2'b10:   return {1'b1, 3'b001, 2'b00, 1'b0, 1'b0, h, 1'b0};
            default: return {1'b1, 3'b111, 2'b00, 1'b0, 1'b0, h, 1'b0};
        endcase
    endfunction

    function automatic logic [9:0] one_exp(input logic [1:0] k, input logic h, input logic hm,
                                           input logic d, input logic rs);
        if (hm)     return {1'b1, 3'b010, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0};
        else if (d) return {1'b1, rs ? 3'b100 : 3'b011, 2'b00, 1'b0, 1'b0, h, 1'b0};
        else        return clean_exp(k, h);
    endfunction

    task automatic check(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = {resp_vld, resp_code, data_size, wb_src, snarf_en, shared, addr_err};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic sv, input logic [1:0] k, input logic h, input logic hm,
                         input logic d, input logic rs, input logic pe);
        snoop_vld = sv; req_kind = k; hit = h; hitm = hm; defer = d; retry_sel = rs; par_err = pe;
    endtask

    task automatic idle(input string req);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check(req, 10'h000);
    endtask

    // n stalls, then a clean recheck; a fourth stall ends in hard failure.
    task automatic stall_chain(input int n, input logic [1:0] k, input logic d);
        int last;
        last = (n > 3) ? 6 : 2 * n;
        for (int c = 0; c <= last; c++) begin
            if (c % 2 == 1)
                drive(1'b1, k, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // stray strobe: R6 ignored
            else if (c < 2 * n)
                drive(c == 0, k, 1'b1, 1'b1, d, 1'b0, 1'b0);
            else
                drive(1'b0, k, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            if (c < last)
                check("R6 stall quiet", 10'h000);
            else if (n > 3)
                check("R7 fourth stall hard failure", {1'b1, 3'b111, 2'b00, 4'b0000});
            else
                check("R6 recheck two clocks later", clean_exp(k, 1'b0));
        end
        idle("R9 single pulse after stall");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 10'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 10'h000);

        // Sweep of all 64 attribute/snoop combinations: R2 R3 R4 R5 R6
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 16; v++) begin
                logic h, hm, d, rs;
                h = v[0]; hm = v[1]; d = v[2]; rs = v[3];
                if (h && hm) begin
                    stall_chain(1, 2'(k), d);
                end else begin
                    drive(1'b1, 2'(k), h, hm, d, rs, 1'b0);
                    @(negedge clk);
                    check(hm ? "R4 dirty hit" : d ? "R5 defer" : h ? "R3 shared" : "R2 clean",
                          one_exp(2'(k), h, hm, d, rs));
                    idle("R9 single pulse");
                end
            end
        end

        // R7: stall chains of length 2, 3 and 4
        stall_chain(2, 2'b01, 1'b0);
        stall_chain(3, 2'b00, 1'b1);
        stall_chain(4, 2'b00, 1'b0);
        stall_chain(4, 2'b10, 1'b1);
        stall_chain(3, 2'b10, 1'b0);   // count restarted after the hard failure (R7)

        // R8: parity error together with a strobe
        drive(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 aerr drops same-clock strobe", {9'h000, 1'b1});
        idle("R8 aerr is one clock");

        // R8: parity error while a stall recheck is pending
        drive(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R6 stall quiet", 10'h000);
        drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 aerr during stall", {9'h000, 1'b1});
        drive(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 pending recheck discarded", 10'h000);
        idle("R8 no late response");

        drive(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 sample after parity recovery", clean_exp(2'b01, 1'b1));
        idle("R9 single pulse");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule